// File: doc/BRIEF.md
# Prescaled 16-bit Timer/Counter with Buffered Access

This block is a 16-bit up-counter kept as a low byte and a high byte. An 8-bit control byte, a flag bit and the two count bytes sit on a small byte-wide register bus. The count source is one of two signals. The first is an internal tick at one quarter of the system clock rate. The second is an external pin, and that pin can be synchronized to the system clock or left unsynchronized. A prescaler that divides by 1, 2, 4 or 8 sits between the selected source and the counter.

When the count wraps from FFFFh to 0000h, a sticky flag is set and appears on `irq`. A one-cycle pulse on `clr_evt` from a compare unit clears the count. When the atomic-access control bit is set, the high byte passes through a holding buffer, so that software can read or write the full 16-bit value as one coherent transfer. Two select outputs tell two neighbouring capture/compare units whether this timer or another timer is their timebase.

External counting is controlled by a three-state source machine:
- `SRC_INTERNAL`: the internal tick is used.
- `SRC_WAIT_FALL`: the external pin is selected, but no falling edge has been seen yet.
- `SRC_ARMED`: each rising edge of the pin produces one tick.

The transitions are:
- INTERNAL to WAIT_FALL when the external source is selected.
- WAIT_FALL to ARMED on a falling edge of the pin.
- WAIT_FALL or ARMED back to INTERNAL when the external source is deselected.

Top module: `prescaled_timer`

## Requirements
- R1: After reset, all four registers read 00h: count low (address 0), count high (address 1), control (address 2) and flag (address 3). After reset, `irq`, `unit1_sel` and `unit2_sel` are 0.
- R2: The control bits are: bit 0 run, bit 1 external source, bit 2 no-sync, bits 5:4 scale, bits 6 and 3 the timebase map, bit 7 atomic. With bit 1 = 0, the count advances once every 4 system clocks. The first advance comes 4 clocks after the control write, and bit 2 has no effect.
- R3: Scale 00, 01, 10 and 11 advance the count once per 1, 2, 4 and 8 source ticks respectively.
- R4: With bit 1 = 1, the count advances once per rising edge of `ext_in`, counting only edges that follow a falling edge seen since the external source was selected. This holds with bit 2 = 0 (two-flop synchronized) and with bit 2 = 1 (unsynchronized).
- R5: With run = 0, the count holds its value.
- R6: A wrap from FFFFh to 0000h sets the flag, and `irq` follows the flag. The flag stays set until software writes address 3, which loads the flag from data bit 0. A wrap in the same cycle as that write wins over the write.
- R7: A `clr_evt` pulse clears the count to 0000h. A bus write to a count byte in the same cycle takes priority over the clear.
- R8: With atomic = 0, each count byte is written and read independently, and writing one byte leaves the other unchanged.
- R9: With atomic = 1, a write to address 1 loads only the holding buffer. A later write to address 0 loads {buffer, data} into the count in one cycle.
- R10: With atomic = 1, a read strobe on address 0 copies the current count high byte into the buffer. Reads of address 1 then return the buffer.
- R11: The outputs depend on the map bits {bit 6, bit 3}. With 00, both `unit1_sel` and `unit2_sel` are 0. With 01, `unit1_sel` = 0 and `unit2_sel` = 1. With 1x, both are 1.
- R12: A write to address 0, 1 or 2 restarts the prescaler and the internal tick phase. The next count advance then comes exactly 4 × scale clocks after the write.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| bus_addr | input | 2 | Register address: 0 count low, 1 count high, 2 control, 3 flag |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe; only has an effect on address 0 in atomic mode |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for the addressed register (combinational) |
| ext_in | input | 1 | External count clock |
| clr_evt | input | 1 | Count clear pulse from a compare unit |
| irq | output | 1 | Sticky wrap flag |
| unit1_sel | output | 1 | 1 when this timer is the timebase for unit 1 |
| unit2_sel | output | 1 | 1 when this timer is the timebase for unit 2 |

## Verification
The bench looks for a phase error in the internal tick. An off-by-one there shifts every count in the scale table by one, and a design that failed to restart the prescaler on a register write would land its first advance early.

External runs begin with a rising edge that comes before any falling edge. A design that skipped the arming step would report one count too many.

In atomic mode, the bench reads the raw high byte after a buffered write. A design that wrote through would show the new byte before the low-byte commit. A design that did not latch on the low read would return a stale or live high byte instead.

The wrap is checked one cycle before and on the wrap edge, and a clear pulse is applied together with a byte write. An inverted priority between clear and write would leave a zero count where the written byte belongs.

// File: rtl/timer_pkg.sv
package timer_pkg;

    localparam int BYTE_W  = 8;
    localparam int CNT_W   = 2 * BYTE_W;
    localparam int SCALE_W = 2;
    localparam int PS_W    = (1 << SCALE_W) - 1;
    localparam int SRC_DIV = 4;

    typedef enum logic [1:0] {
        SRC_INTERNAL  = 2'd0,
        SRC_WAIT_FALL = 2'd1,
        SRC_ARMED     = 2'd2
    } src_state_t;

    typedef enum logic [1:0] {
        ADDR_LO   = 2'd0,
        ADDR_HI   = 2'd1,
        ADDR_CTRL = 2'd2,
        ADDR_FLAG = 2'd3
    } addr_t;

    typedef struct packed {
        logic               atomic;
        logic               map_hi;
        logic [SCALE_W-1:0] scale;
        logic               map_lo;
        logic               ext_async;
        logic               ext_sel;
        logic               run;
    } ctrl_t;

endpackage

// File: rtl/tick_source.sv
module tick_source
    import timer_pkg::*;
#(
    parameter int DIV = SRC_DIV
) (
    input  logic clk,
    input  logic rst_n,
    input  logic ext_sel,
    input  logic ext_async,
    input  logic ext_in,
    input  logic restart,
    output logic tick
);
    localparam int PH_W = (DIV > 1) ? $clog2(DIV) : 1;

    logic [PH_W-1:0] phase;
    logic            tick_int;
    logic            sync1, sync2, sync3, raw_q;
    logic            lvl, lvl_prev, rise, fall;
    src_state_t      state, state_nx;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            phase <= '0;
        end else if (restart || phase == PH_W'(DIV - 1)) begin
            phase <= '0;
        end else begin
            phase <= phase + PH_W'(1);
        end
    end

    assign tick_int = (phase == PH_W'(DIV - 1));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sync1 <= 1'b0;
            sync2 <= 1'b0;
            sync3 <= 1'b0;
            raw_q <= 1'b0;
        end else begin
            sync1 <= ext_in;
            sync2 <= sync1;
            sync3 <= sync2;
            raw_q <= ext_in;
        end
    end

    assign lvl      = ext_async ? ext_in : sync2;
    assign lvl_prev = ext_async ? raw_q  : sync3;
    assign rise     = lvl & ~lvl_prev;
    assign fall     = ~lvl & lvl_prev;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= SRC_INTERNAL;
        end else begin
            state <= state_nx;
        end
    end

    always_comb begin
        state_nx = state;
        unique case (state)
            SRC_INTERNAL:  if (ext_sel) state_nx = SRC_WAIT_FALL;
            SRC_WAIT_FALL: begin
                if (!ext_sel)  state_nx = SRC_INTERNAL;
                else if (fall) state_nx = SRC_ARMED;
            end
            SRC_ARMED:     if (!ext_sel) state_nx = SRC_INTERNAL;
            default:       state_nx = SRC_INTERNAL;
        endcase
    end

    always_comb begin
        unique case (state)
            SRC_INTERNAL:  tick = tick_int;
            SRC_WAIT_FALL: tick = 1'b0;
            SRC_ARMED:     tick = rise;
            default:       tick = 1'b0;
        endcase
    end

endmodule

// File: rtl/prescaler.sv
module prescaler
    import timer_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic               tick,
    input  logic               run,
    input  logic [SCALE_W-1:0] scale,
    input  logic               clear,
    output logic               inc
);
    logic [PS_W-1:0] pcnt;
    logic [PS_W-1:0] lim;

    assign lim = (PS_W'(1) << scale) - PS_W'(1);
    assign inc = tick & run & ~clear & (pcnt == lim);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pcnt <= '0;
        end else if (clear) begin
            pcnt <= '0;
        end else if (tick && run) begin
            pcnt <= (pcnt == lim) ? '0 : pcnt + PS_W'(1);
        end
    end

endmodule

// File: rtl/count_core.sv
module count_core
    import timer_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              inc,
    input  logic              clr,
    input  logic              wr_lo,
    input  logic              wr_hi,
    input  logic              rd_lo,
    input  logic              atomic,
    input  logic [BYTE_W-1:0] wdata,
    output logic [CNT_W-1:0]  count,
    output logic [BYTE_W-1:0] hbuf,
    output logic              wrap
);
    logic wr_direct;

    assign wr_direct = wr_lo | (wr_hi & ~atomic);
    assign wrap      = inc & (&count) & ~wr_direct & ~clr;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            count <= '0;
        end else if (wr_lo) begin
            count <= atomic ? {hbuf, wdata} : {count[CNT_W-1:BYTE_W], wdata};
        end else if (wr_hi && !atomic) begin
            count[CNT_W-1:BYTE_W] <= wdata;
        end else if (clr) begin
            count <= '0;
        end else if (inc) begin
            count <= count + CNT_W'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            hbuf <= '0;
        end else if (wr_hi && atomic) begin
            hbuf <= wdata;
        end else if (rd_lo && atomic) begin
            hbuf <= count[CNT_W-1:BYTE_W];
        end
    end

endmodule

// File: rtl/prescaled_timer.sv
module prescaled_timer
    import timer_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [1:0]        bus_addr,
    input  logic              bus_wr,
    input  logic              bus_rd,
    input  logic [BYTE_W-1:0] bus_wdata,
    output logic [BYTE_W-1:0] bus_rdata,
    input  logic              ext_in,
    input  logic              clr_evt,
    output logic              irq,
    output logic              unit1_sel,
    output logic              unit2_sel
);
    ctrl_t             ctrl_q;
    logic              flag_q;
    logic              wr_lo, wr_hi, wr_ctrl, wr_flag, rd_lo, restart;
    logic              tick, inc, wrap;
    logic [CNT_W-1:0]  count_q;
    logic [BYTE_W-1:0] hbuf;

    assign wr_lo   = bus_wr & (bus_addr == ADDR_LO);
    assign wr_hi   = bus_wr & (bus_addr == ADDR_HI);
    assign wr_ctrl = bus_wr & (bus_addr == ADDR_CTRL);
    assign wr_flag = bus_wr & (bus_addr == ADDR_FLAG);
    assign rd_lo   = bus_rd & (bus_addr == ADDR_LO);
    assign restart = wr_lo | wr_hi | wr_ctrl;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctrl_q <= '0;
        end else if (wr_ctrl) begin
            ctrl_q <= ctrl_t'(bus_wdata);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            flag_q <= 1'b0;
        end else if (wrap) begin
            flag_q <= 1'b1;
        end else if (wr_flag) begin
            flag_q <= bus_wdata[0];
        end
    end

    tick_source #(.DIV(SRC_DIV)) src_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .ext_sel   (ctrl_q.ext_sel),
        .ext_async (ctrl_q.ext_async),
        .ext_in    (ext_in),
        .restart   (restart),
        .tick      (tick)
    );

    prescaler pre_i (
        .clk   (clk),
        .rst_n (rst_n),
        .tick  (tick),
        .run   (ctrl_q.run),
        .scale (ctrl_q.scale),
        .clear (restart),
        .inc   (inc)
    );

    count_core core_i (
        .clk    (clk),
        .rst_n  (rst_n),
        .inc    (inc),
        .clr    (clr_evt),
        .wr_lo  (wr_lo),
        .wr_hi  (wr_hi),
        .rd_lo  (rd_lo),
        .atomic (ctrl_q.atomic),
        .wdata  (bus_wdata),
        .count  (count_q),
        .hbuf   (hbuf),
        .wrap   (wrap)
    );

    always_comb begin
        unique case (addr_t'(bus_addr))
            ADDR_LO:   bus_rdata = count_q[BYTE_W-1:0];
            ADDR_HI:   bus_rdata = ctrl_q.atomic ? hbuf : count_q[CNT_W-1:BYTE_W];
            ADDR_CTRL: bus_rdata = ctrl_q;
            ADDR_FLAG: bus_rdata = {{(BYTE_W-1){1'b0}}, flag_q};
            default:   bus_rdata = '0;
        endcase
    end

    assign irq       = flag_q;
    assign unit1_sel = ctrl_q.map_hi;
    assign unit2_sel = ctrl_q.map_hi | ctrl_q.map_lo;

endmodule

// File: rtl/prescaled_timer_chk.sv
module prescaled_timer_chk
    import timer_pkg::*;
(
    input logic             clk,
    input logic             rst_n,
    input logic             clr_evt,
    input logic             bus_wr,
    input logic [1:0]       bus_addr,
    input logic             run,
    input logic             inc,
    input logic [CNT_W-1:0] count,
    input logic             irq,
    input logic             unit1_sel,
    input logic             unit2_sel
);

    assert_clear_zero_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_evt && !bus_wr) |=> (count == '0));

    assert_wrap_flag_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (inc && (&count) && !clr_evt && !bus_wr) |=> irq);

    assert_flag_sticky_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (irq && !(bus_wr && bus_addr == ADDR_FLAG)) |=> irq);

    assert_hold_when_stopped_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (!run && !bus_wr && !clr_evt) |=> $stable(count));

    assert_step_by_one_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (inc && !bus_wr && !clr_evt) |=> (count == $past(count) + CNT_W'(1)));

    assert_select_nesting_R11: assert property (@(posedge clk) disable iff (!rst_n)
        unit1_sel |-> unit2_sel);

endmodule

bind prescaled_timer prescaled_timer_chk chk_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .clr_evt   (clr_evt),
    .bus_wr    (bus_wr),
    .bus_addr  (bus_addr),
    .run       (ctrl_q.run),
    .inc       (inc),
    .count     (count_q),
    .irq       (irq),
    .unit1_sel (unit1_sel),
    .unit2_sel (unit2_sel)
);

// File: tb/prescaled_timer_tb_top.sv
`timescale 1ns/1ps
module prescaled_timer_tb_top;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [1:0] bus_addr = 2'd0;
    logic       bus_wr = 1'b0;
    logic       bus_rd = 1'b0;
    logic [7:0] bus_wdata = 8'h00;
    logic [7:0] bus_rdata;
    logic       ext_in = 1'b0;
    logic       clr_evt = 1'b0;
    logic       irq, unit1_sel, unit2_sel;

    int  n_checks = 0;
    int  n_fail = 0;
    bit  done = 1'b0;

    always #10 clk = ~clk;

    prescaled_timer dut_i (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
        .bus_rd(bus_rd), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .ext_in(ext_in), .clr_evt(clr_evt), .irq(irq),
        .unit1_sel(unit1_sel), .unit2_sel(unit2_sel)
    );

    typedef struct packed {
        logic [7:0]  ctrl;
        logic [7:0]  pulses;
        logic [15:0] wait_cyc;
        logic [7:0]  exp_lo;
        logic [3:0]  req;
    } vec_t;

    localparam int NV = 8;
    localparam vec_t VECS [NV] = '{
        '{8'h01, 8'd0,  16'd400, 8'd100, 4'd2},  // R2 internal, 1:1
        '{8'h05, 8'd0,  16'd400, 8'd100, 4'd2},  // R2 no-sync bit ignored
        '{8'h11, 8'd0,  16'd400, 8'd50,  4'd3},  // R3 1:2
        '{8'h21, 8'd0,  16'd400, 8'd25,  4'd3},  // R3 1:4
        '{8'h31, 8'd0,  16'd400, 8'd12,  4'd3},  // R3 1:8
        '{8'h03, 8'd10, 16'd0,   8'd9,   4'd4},  // R4 synced, first rise dropped
        '{8'h07, 8'd10, 16'd0,   8'd9,   4'd4},  // R4 unsynced
        '{8'h13, 8'd9,  16'd0,   8'd4,   4'd4}   // R4 synced with 1:2
    };

    task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [1:0] a, input logic [7:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd_strobe(input logic [1:0] a);
        @(negedge clk);
        bus_addr = a; bus_rd = 1'b1;
        @(negedge clk);
        bus_rd = 1'b0;
    endtask

    task automatic peek(input logic [1:0] a, output logic [7:0] v);
        bus_addr = a;
        #1;
        v = bus_rdata;
    endtask

    task automatic pulses(input int n);
        for (int i = 0; i < n; i++) begin
            ext_in = 1'b1;
            repeat (4) @(negedge clk);
            ext_in = 1'b0;
            repeat (4) @(negedge clk);
        end
        repeat (8) @(negedge clk);
    endtask

    initial begin : watchdog
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
            $finish;
        end
    end

    initial begin : main
        logic [7:0] v;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        peek(2'd0, v); check("R1 count low", v, 8'h00);
        peek(2'd1, v); check("R1 count high", v, 8'h00);
        peek(2'd2, v); check("R1 control", v, 8'h00);
        peek(2'd3, v); check("R1 flag", v, 8'h00);
        check("R1 irq", {7'd0, irq}, 8'h00);
        check("R1 selects", {6'd0, unit1_sel, unit2_sel}, 8'h00);

        // table walk: R2 R3 R4
        for (int k = 0; k < NV; k++) begin
            wr(2'd2, 8'h00);
            wr(2'd0, 8'h00);
            wr(2'd1, 8'h00);
            wr(2'd2, VECS[k].ctrl);
            if (VECS[k].pulses != 0) begin
                pulses(int'(VECS[k].pulses));
            end else begin
                repeat (int'(VECS[k].wait_cyc)) @(posedge clk);
                @(negedge clk);
            end
            peek(2'd0, v);
            check($sformatf("R%0d vector %0d", VECS[k].req, k), v, VECS[k].exp_lo);
        end

        // R5 stopped counter holds
        wr(2'd2, 8'h00);
        wr(2'd0, 8'h42);
        wr(2'd1, 8'h00);
        repeat (100) @(negedge clk);
        peek(2'd0, v); check("R5 hold internal", v, 8'h42);
        wr(2'd2, 8'h02);
        pulses(5);
        peek(2'd0, v); check("R5 hold external", v, 8'h42);

        // R6 wrap flag
        wr(2'd2, 8'h00);
        wr(2'd0, 8'hFF);
        wr(2'd1, 8'hFF);
        wr(2'd2, 8'h01);
        repeat (3) @(posedge clk);
        @(negedge clk);
        peek(2'd0, v); check("R6 before wrap low", v, 8'hFF);
        peek(2'd3, v); check("R6 before wrap flag", v, 8'h00);
        @(posedge clk);
        @(negedge clk);
        peek(2'd0, v); check("R6 wrapped low", v, 8'h00);
        peek(2'd1, v); check("R6 wrapped high", v, 8'h00);
        peek(2'd3, v); check("R6 flag set", v, 8'h01);
        wr(2'd2, 8'h00);
        repeat (10) @(negedge clk);
        check("R6 irq sticky", {7'd0, irq}, 8'h01);
        wr(2'd3, 8'h00);
        peek(2'd3, v); check("R6 flag cleared", v, 8'h00);
        check("R6 irq cleared", {7'd0, irq}, 8'h00);

        // R7 clear pulse and its priority
        wr(2'd0, 8'h34);
        wr(2'd1, 8'h12);
        @(negedge clk);
        clr_evt = 1'b1;
        @(negedge clk);
        clr_evt = 1'b0;
        peek(2'd0, v); check("R7 cleared low", v, 8'h00);
        peek(2'd1, v); check("R7 cleared high", v, 8'h00);
        wr(2'd1, 8'h12);
        @(negedge clk);
        bus_addr = 2'd0; bus_wdata = 8'h77; bus_wr = 1'b1; clr_evt = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0; clr_evt = 1'b0;
        peek(2'd0, v); check("R7 write beats clear low", v, 8'h77);
        peek(2'd1, v); check("R7 write beats clear high", v, 8'h12);

        // R8 independent byte access
        wr(2'd0, 8'h34);
        wr(2'd1, 8'h56);
        peek(2'd0, v); check("R8 low untouched by high write", v, 8'h34);
        peek(2'd1, v); check("R8 high written", v, 8'h56);

        // R9 buffered write
        wr(2'd0, 8'h00);
        wr(2'd1, 8'h00);
        wr(2'd2, 8'h80);
        wr(2'd1, 8'h12);
        wr(2'd2, 8'h00);
        peek(2'd1, v); check("R9 high not yet committed", v, 8'h00);
        wr(2'd2, 8'h80);
        wr(2'd0, 8'h34);
        wr(2'd2, 8'h00);
        peek(2'd1, v); check("R9 committed high", v, 8'h12);
        peek(2'd0, v); check("R9 committed low", v, 8'h34);

        // R10 latched read
        wr(2'd0, 8'hCD);
        wr(2'd1, 8'hAB);
        wr(2'd2, 8'h80);
        rd_strobe(2'd0);
        wr(2'd2, 8'h00);
        wr(2'd1, 8'h55);
        wr(2'd2, 8'h80);
        peek(2'd1, v); check("R10 buffered high", v, 8'hAB);
        wr(2'd2, 8'h00);
        peek(2'd1, v); check("R10 live high", v, 8'h55);

        // R11 timebase select
        wr(2'd2, 8'h08);
        check("R11 map 01", {6'd0, unit1_sel, unit2_sel}, 8'h01);
        wr(2'd2, 8'h40);
        check("R11 map 10", {6'd0, unit1_sel, unit2_sel}, 8'h03);
        wr(2'd2, 8'h48);
        check("R11 map 11", {6'd0, unit1_sel, unit2_sel}, 8'h03);
        wr(2'd2, 8'h00);
        check("R11 map 00", {6'd0, unit1_sel, unit2_sel}, 8'h00);

        // R12 register write restarts prescaler
        wr(2'd2, 8'h31);
        repeat (20) @(negedge clk);
        wr(2'd0, 8'h00);
        repeat (31) @(posedge clk);
        @(negedge clk);
        peek(2'd0, v); check("R12 before first advance", v, 8'h00);
        @(posedge clk);
        @(negedge clk);
        peek(2'd0, v); check("R12 first advance", v, 8'h01);

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
        $finish;
    end

endmodule